// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host reach a bank of 32-bit registers over a four-wire serial link with chip select, clock idling low, and data taken on the rising clock edge. Each transaction sends an 8-bit command and then an 8-bit register address. After that come one or more 32-bit data words, most significant bit first. Three command pairs are accepted: a read and a write with a fixed address, a read and a write whose address counts up between words, and a read and a write whose address counts down between words. Any other command is ignored for the rest of the transaction.

The serial pins are brought into the system clock domain through a short synchroniser, and all logic runs on the system clock. The serial clock must therefore stay in each phase for at least eight system clock cycles. The register side is a simple parallel interface. It has an address, a one-cycle write strobe with its data word, and a one-cycle snapshot strobe that marks the cycle in which the read word is captured from the register bank. A one-cycle commit pulse tells the bank that a read word was fully shifted out, so any clear-on-read bits can now be cleared. The serial output comes as a data bit and a separate output enable for the pad's tri-state buffer.

Top module: `spi_regport`

## Requirements
- R1: After reset, and whenever chip select has been high for several system clock cycles, the output enable is low and none of the write, snapshot or commit strobes is asserted.
- R2: The accepted command codes are 0x03 (read, fixed), 0x0B (read, counting up), 0x07 (read, counting down), 0x02 (write, fixed), 0x0A (write, counting up) and 0x06 (write, counting down). Any other code leaves the output enable low and produces no strobe until chip select rises.
- R3: For a read, the output drives the most significant bit of the word on the falling edge that follows the rising edge of the last address bit. Each later falling edge presents the next lower bit, and the output enable stays high until chip select rises.
- R4: Each read word is captured in full at its start, in the cycle of the snapshot strobe. A change of the register value while the word is being shifted does not alter the bits sent.
- R5: The commit pulse lasts one cycle and is issued, with the word's address on the address port, only after the 32nd bit of a read word has been taken by the host. A read word cut short by chip select rising produces no commit pulse.
- R6: For a write, data bits are taken on rising edges, most significant bit first. A one-cycle write strobe carrying the full word is issued only when all 32 bits have arrived. A partial word at chip-select release produces no strobe.
- R7: Within a burst, the address stays the same, goes up by one, or goes down by one between consecutive words, as the command selects.
- R8: Counting up from the highest implemented address wraps to 0. Counting down from address 0 wraps to the highest implemented address, which is given by the parameter MAX_ADDR (default 63).
- R9: For an address above MAX_ADDR, a read returns all zeros, and no write, snapshot or commit strobe is issued.
- R10: Raising chip select ends the transaction and drops the output enable. The next transaction starts with command decode, even if the previous one stopped in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Enable for the tri-state buffer of the serial output pad |
| reg_addr | output | 8 | Register address for the current word |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Write data, valid with reg_wr |
| reg_rd | output | 1 | One-cycle snapshot strobe; reg_rdata is captured in this cycle |
| reg_rdata | input | 32 | Read data for reg_addr, combinational from the bank |
| reg_clr | output | 1 | One-cycle commit pulse after a read word completes |

## Verification
Two actions can collide. One is the commit of the word just read. The other is the snapshot of the next word at a fixed address in the same burst. If the snapshot came before the clear, or at the same time, a clear-on-read register would send its old value twice. The bench reads a clear-on-read register twice in a fixed-address burst and expects the second word to be zero. It also uses a counting burst that crosses into the clear-on-read range, and matches the logged commit addresses against the expected address sequence. The write strobe and the address step between burst words are checked the same way, from the logged addresses of a burst that wraps past the top address.

// File: rtl/spi_regport_pkg.sv
// Package: shared command codes, address step modes, FSM states and decode.
// Assumes 8-bit command codes; all other widths are parameters of the modules.
package spi_regport_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] CMD_WR_FIX = 8'h02;
    localparam logic [OP_W-1:0] CMD_RD_FIX = 8'h03;
    localparam logic [OP_W-1:0] CMD_WR_DN  = 8'h06;
    localparam logic [OP_W-1:0] CMD_RD_DN  = 8'h07;
    localparam logic [OP_W-1:0] CMD_WR_UP  = 8'h0A;
    localparam logic [OP_W-1:0] CMD_RD_UP  = 8'h0B;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef enum logic [2:0] {
        ST_CMD    = 3'd0,
        ST_ADDR   = 3'd1,
        ST_READ   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_IGNORE = 3'd4
    } state_e;

    typedef struct packed {
        logic  valid;
        logic  is_read;
        step_e step;
    } cmd_t;

    // Turns a received command byte into direction, step mode and validity.
    function automatic cmd_t decode_cmd(input logic [OP_W-1:0] code);
        cmd_t c;
        c = '{valid: 1'b1, is_read: 1'b0, step: STEP_HOLD};
        case (code)
            CMD_RD_FIX: begin c.is_read = 1'b1; c.step = STEP_HOLD; end
            CMD_RD_UP:  begin c.is_read = 1'b1; c.step = STEP_UP;   end
            CMD_RD_DN:  begin c.is_read = 1'b1; c.step = STEP_DOWN; end
            CMD_WR_FIX: begin c.is_read = 1'b0; c.step = STEP_HOLD; end
            CMD_WR_UP:  begin c.is_read = 1'b0; c.step = STEP_UP;   end
            CMD_WR_DN:  begin c.is_read = 1'b0; c.step = STEP_DOWN; end
            default:    c.valid = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Module: multi-bit flop synchroniser for slow asynchronous pins.
// Assumes each bit is independently sampled; no multi-bit coherence is needed
// because the serial clock phases are much longer than the pipeline.
module spi_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    // Shifts the raw pins through STAGES flops.
    always_ff @(posedge clk) begin : sync_pipe
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RESET_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_edge_det.sv
// Module: rising and falling edge pulses of an already synchronised signal.
// Assumes the input is stable for at least two clock cycles between changes.
module spi_edge_det #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);

    logic sig_q;

    // Keeps the previous sample for comparison.
    always_ff @(posedge clk) begin : prev_sample
        if (!rst_n) sig_q <= IDLE_VAL;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;

endmodule

// File: rtl/spi_addr_seq.sv
// Module: register address holder with hold / up / down stepping and wrap.
// Assumes MAX_ADDR fits in ADDR_W bits; addresses above MAX_ADDR are
// reported as out of range so the bank is not touched.
module spi_addr_seq
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int MAX_ADDR = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              advance,
    input  step_e             step,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MAX_ADDR);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;

    // Works out the address of the following burst word.
    always_comb begin : next_addr
        case (step)
            STEP_UP:   addr_next = (addr_q >= TOP_ADDR) ? '0 : addr_q + 1'b1;
            STEP_DOWN: addr_next = (addr_q == '0) ? TOP_ADDR : addr_q - 1'b1;
            default:   addr_next = addr_q;
        endcase
    end

    // Loads the start address or steps it between words.
    always_ff @(posedge clk) begin : addr_reg
        if (!rst_n)       addr_q <= '0;
        else if (load)    addr_q <= load_val;
        else if (advance) addr_q <= addr_next;
    end

    assign addr     = addr_q;
    assign in_range = (addr_q <= TOP_ADDR);

endmodule

// File: rtl/spi_shift_unit.sv
// Module: receive and transmit shift registers, MSB first.
// Assumes the controller issues rx_en on serial rising edges and tx_shift on
// falling edges; tx_load must come before the first tx_shift of a word.
module spi_shift_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_bit,
    output logic [DATA_W-1:0] rx_next,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_val,
    input  logic              tx_shift,
    output logic              tx_bit
);

    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic              tx_bit_q;

    assign rx_next = {rx_q[DATA_W-2:0], rx_bit};

    // Collects incoming bits.
    always_ff @(posedge clk) begin : rx_shift
        if (!rst_n)     rx_q <= '0;
        else if (rx_en) rx_q <= rx_next;
    end

    // Captures the read word and presents one bit per falling edge.
    always_ff @(posedge clk) begin : tx_path
        if (!rst_n) begin
            tx_q     <= '0;
            tx_bit_q <= 1'b0;
        end else if (tx_load) begin
            tx_q <= tx_val;
        end else if (tx_shift) begin
            tx_bit_q <= tx_q[DATA_W-1];
            tx_q     <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    assign tx_bit = tx_bit_q;

endmodule

// File: rtl/spi_regport.sv
// Module: serial slave giving a host read/write access to a register bank.
// Assumes the serial clock stays in each phase for at least 8 clk cycles,
// reg_rdata answers reg_addr combinationally, and chip select high holds
// the transaction logic cleared so each access starts with command decode.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int MAX_ADDR    = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_clr
);

    localparam int              CNT_W     = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);

    logic              sck_s, cs_s, mosi_s;
    logic              sck_rise, sck_fall;
    logic [DATA_W-1:0] rx_next;
    logic              in_range;
    logic              addr_load;
    cmd_t              cmd_dec;

    state_e            state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              is_read_q;
    step_e             step_q;
    logic              oe_q, wr_q, clr_q, adv_q, load_q;
    logic [DATA_W-1:0] wdata_q;

    spi_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sck, spi_cs_n, spi_mosi}),
        .dout ({sck_s, cs_s, mosi_s})
    );

    spi_edge_det #(.IDLE_VAL(1'b0)) u_sck_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sck_s),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (sck_rise & ~cs_s),
        .rx_bit  (mosi_s),
        .rx_next (rx_next),
        .tx_load (load_q),
        .tx_val  (in_range ? reg_rdata : '0),
        .tx_shift(sck_fall & ~cs_s & (state_q == ST_READ)),
        .tx_bit  (spi_miso)
    );

    assign addr_load = ~cs_s & sck_rise & (state_q == ST_ADDR) & (cnt_q == ADDR_LAST);

    spi_addr_seq #(
        .ADDR_W  (ADDR_W),
        .MAX_ADDR(MAX_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_load),
        .load_val(rx_next[ADDR_W-1:0]),
        .advance (adv_q),
        .step    (step_q),
        .addr    (reg_addr),
        .in_range(in_range)
    );

    assign cmd_dec = decode_cmd(rx_next[OP_W-1:0]);

    // Transaction sequencer: command, address, then data words.
    always_ff @(posedge clk) begin : fsm
        if (!rst_n || cs_s) begin
            state_q   <= ST_CMD;
            cnt_q     <= '0;
            oe_q      <= 1'b0;
            wr_q      <= 1'b0;
            clr_q     <= 1'b0;
            adv_q     <= 1'b0;
            load_q    <= 1'b0;
            is_read_q <= 1'b0;
            step_q    <= STEP_HOLD;
        end else begin
            wr_q   <= 1'b0;
            clr_q  <= 1'b0;
            adv_q  <= 1'b0;
            load_q <= adv_q & (state_q == ST_READ);
            case (state_q)
                ST_CMD: begin
                    if (sck_rise) begin
                        if (cnt_q == OP_LAST) begin
                            cnt_q     <= '0;
                            is_read_q <= cmd_dec.is_read;
                            step_q    <= cmd_dec.step;
                            state_q   <= cmd_dec.valid ? ST_ADDR : ST_IGNORE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        if (cnt_q == ADDR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= is_read_q ? ST_READ : ST_WRITE;
                            load_q  <= is_read_q;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (sck_fall) oe_q <= 1'b1;
                    if (sck_rise) begin
                        if (cnt_q == WORD_LAST) begin
                            cnt_q <= '0;
                            clr_q <= in_range;
                            adv_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (sck_rise) begin
                        if (cnt_q == WORD_LAST) begin
                            cnt_q <= '0;
                            wr_q  <= in_range;
                            adv_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Holds the completed write word for the strobe cycle.
    always_ff @(posedge clk) begin : wdata_reg
        if (!rst_n) wdata_q <= '0;
        else if (!cs_s && sck_rise && state_q == ST_WRITE && cnt_q == WORD_LAST)
            wdata_q <= rx_next;
    end

    assign spi_miso_oe = oe_q;
    assign reg_wr      = wr_q;
    assign reg_wdata   = wdata_q;
    assign reg_clr     = clr_q;
    assign reg_rd      = load_q & in_range;

endmodule

// File: rtl/spi_regport_chk.sv
// Module: protocol checker bound to spi_regport.
// Assumes the serial pins settle through the synchroniser within 4 cycles.
module spi_regport_chk #(
    parameter int ADDR_W   = 8,
    parameter int MAX_ADDR = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso_oe,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              reg_clr
);

    logic [2:0] cs_hi_cnt;

    // Counts consecutive cycles with chip select high, saturating at 4.
    always_ff @(posedge clk) begin : cs_hi_count
        if (!rst_n || !spi_cs_n) cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 3'd4) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt == 3'd4) |-> (!spi_miso_oe && !reg_wr && !reg_rd && !reg_clr));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd, reg_clr}));

    assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr |=> !reg_clr);

    assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_clr) |-> $stable(reg_addr));

    assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd || reg_clr) |-> (reg_addr <= ADDR_W'(MAX_ADDR)));

endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W), .MAX_ADDR(MAX_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_miso_oe(spi_miso_oe),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_clr    (reg_clr)
);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;

    localparam int H    = 8;
    localparam int MAXA = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [7:0]  reg_addr;
    logic        reg_wr, reg_rd, reg_clr;
    logic [31:0] reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    spi_regport u_spi_regport (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_clr(reg_clr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Register bank model: addresses 32..63 clear on a committed read.
    logic [31:0] mem [64];
    int          wr_n = 0, clr_n = 0, oe_cnt = 0;
    logic [7:0]  wr_a [64];
    logic [31:0] wr_d [64];
    logic [7:0]  clr_a [64];
    logic        poke_en = 1'b0;
    logic [5:0]  poke_addr = '0;
    logic [31:0] poke_val = '0;

    assign reg_rdata = (reg_addr <= 8'(MAXA)) ? mem[reg_addr[5:0]] : 32'hDEAD_BEEF;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 | 32'(i);
        end else begin
            if (poke_en) mem[poke_addr] <= poke_val;
            if (reg_wr) begin
                mem[reg_addr[5:0]] <= reg_wdata;
                wr_a[wr_n % 64] <= reg_addr;
                wr_d[wr_n % 64] <= reg_wdata;
                wr_n <= wr_n + 1;
            end
            if (reg_clr) begin
                if (reg_addr >= 8'd32) mem[reg_addr[5:0]] <= '0;
                clr_a[clr_n % 64] <= reg_addr;
                clr_n <= clr_n + 1;
            end
            if (spi_miso_oe) oe_cnt <= oe_cnt + 1;
        end
    end

    // {command, address, first data word, word count}
    localparam logic [55:0] VEC [11] = '{
        {8'h02, 8'h05, 32'h1111_1111, 8'd1},
        {8'h0A, 8'h3E, 32'h2222_0000, 8'd3},
        {8'h06, 8'h01, 32'h3333_0000, 8'd3},
        {8'h03, 8'h05, 32'h0,         8'd2},
        {8'h0B, 8'h3F, 32'h0,         8'd2},
        {8'h07, 8'h00, 32'h0,         8'd2},
        {8'h03, 8'h20, 32'h0,         8'd2},
        {8'h02, 8'h50, 32'h4444_4444, 8'd1},
        {8'h03, 8'h50, 32'h0,         8'd1},
        {8'h0F, 8'h05, 32'h0,         8'd1},
        {8'h0B, 8'h1E, 32'h0,         8'd3}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] step_addr(input logic [7:0] a, input logic [7:0] op);
        if (op == 8'h0A || op == 8'h0B) return (a >= 8'(MAXA)) ? 8'd0 : a + 8'd1;
        if (op == 8'h06 || op == 8'h07) return (a == 8'd0) ? 8'(MAXA) : a - 8'd1;
        return a;
    endfunction

    task automatic spi_bit(input logic b, output logic r);
        spi_mosi = b;
        repeat (H) @(negedge clk);
        r = spi_miso;
        spi_sck = 1'b1;
        repeat (H) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    task automatic spi_start();
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic spi_end();
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic r;
        for (int i = n - 1; i >= 0; i--) spi_bit(v[i], r);
    endtask

    task automatic read_bits(input int n, output logic [31:0] w);
        logic r;
        w = '0;
        for (int i = 0; i < n; i++) begin
            spi_bit(1'b0, r);
            w = {w[30:0], r};
        end
    endtask

    task automatic run_vec(input logic [55:0] v);
        logic [7:0]  op, cur;
        logic [31:0] d, w, exp;
        logic [7:0]  exp_a [8];
        int          n, hits, wr0, clr0, oe0;
        bit          is_rd, is_wr;
        op = v[55:48]; cur = v[47:40]; d = v[39:8]; n = int'(v[7:0]);
        is_rd = (op == 8'h03 || op == 8'h0B || op == 8'h07);
        is_wr = (op == 8'h02 || op == 8'h0A || op == 8'h06);
        wr0 = wr_n; clr0 = clr_n; oe0 = oe_cnt; hits = 0;
        spi_start();
        send_bits({24'd0, op}, 8);
        send_bits({24'd0, cur}, 8);
        for (int k = 0; k < n; k++) begin
            if (is_wr) begin
                send_bits(d + 32'(k), 32);
            end else begin
                exp = (cur <= 8'(MAXA)) ? mem[cur[5:0]] : 32'h0;
                read_bits(32, w);
                // R3 R4 R9: word content, MSB first, zero when out of range
                if (is_rd) chk(w == exp, "R3 read word", w, exp);
            end
            if (cur <= 8'(MAXA)) begin
                exp_a[hits] = cur;
                hits++;
            end
            cur = step_addr(cur, op);
        end
        spi_end();
        if (!is_rd && !is_wr) begin
            chk(wr_n == wr0 && clr_n == clr0 && oe_cnt == oe0, "R2 unsupported command",
                32'(wr_n - wr0 + clr_n - clr0 + oe_cnt - oe0), 32'd0);
        end else if (is_wr) begin
            chk(wr_n - wr0 == hits, "R6 write strobe count", 32'(wr_n - wr0), 32'(hits));
            chk(oe_cnt == oe0, "R3 no drive during write", 32'(oe_cnt - oe0), 32'd0);
            for (int j = 0; j < hits; j++) begin
                chk(wr_a[(wr0 + j) % 64] == exp_a[j], "R7 R8 write address",
                    32'(wr_a[(wr0 + j) % 64]), 32'(exp_a[j]));
                chk(wr_d[(wr0 + j) % 64] == d + 32'(j), "R6 write data",
                    wr_d[(wr0 + j) % 64], d + 32'(j));
            end
        end else begin
            chk(clr_n - clr0 == hits, "R5 commit count", 32'(clr_n - clr0), 32'(hits));
            for (int j = 0; j < hits; j++)
                chk(clr_a[(clr0 + j) % 64] == exp_a[j], "R7 R8 commit address",
                    32'(clr_a[(clr0 + j) % 64]), 32'(exp_a[j]));
        end
        chk(spi_miso_oe == 1'b0, "R10 output released", 32'(spi_miso_oe), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] w;
        int          c0;
        repeat (5) @(negedge clk);
        // R1: quiet outputs during reset
        chk(!spi_miso_oe && !reg_wr && !reg_rd && !reg_clr, "R1 reset state",
            {28'd0, spi_miso_oe, reg_wr, reg_rd, reg_clr}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!spi_miso_oe && !reg_wr && !reg_rd && !reg_clr, "R1 idle state",
            {28'd0, spi_miso_oe, reg_wr, reg_rd, reg_clr}, 32'd0);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R4: value changes mid-word; the snapshot word is sent intact
        spi_start();
        send_bits(32'h03, 8);
        send_bits(32'h06, 8);
        read_bits(8, w);
        poke_addr = 6'd6; poke_val = 32'h0BAD_F00D; poke_en = 1'b1;
        @(negedge clk); poke_en = 1'b0;
        begin
            logic [31:0] rest;
            read_bits(24, rest);
            w = {w[7:0], rest[23:0]};
        end
        chk(w == 32'hA500_0006, "R4 snapshot held", w, 32'hA500_0006);
        read_bits(32, w);
        chk(w == 32'h0BAD_F00D, "R4 next word recaptured", w, 32'h0BAD_F00D);
        spi_end();

        // R5: partial read of a clear-on-read register leaves it untouched
        c0 = clr_n;
        spi_start();
        send_bits(32'h03, 8);
        send_bits(32'h21, 8);
        read_bits(10, w);
        spi_end();
        chk(clr_n == c0, "R5 no commit on partial word", 32'(clr_n - c0), 32'd0);
        spi_start();
        send_bits(32'h03, 8);
        send_bits(32'h21, 8);
        read_bits(32, w);
        spi_end();
        chk(w == 32'hA500_0021, "R5 value kept after partial", w, 32'hA500_0021);

        // R6: partial write is discarded
        c0 = wr_n;
        spi_start();
        send_bits(32'h02, 8);
        send_bits(32'h07, 8);
        send_bits(32'hFFFFF, 20);
        spi_end();
        chk(wr_n == c0, "R6 no strobe on partial word", 32'(wr_n - c0), 32'd0);

        // R10: abort inside the command byte, next access decodes afresh
        spi_start();
        send_bits(32'h5, 3);
        spi_end();
        spi_start();
        send_bits(32'h03, 8);
        send_bits(32'h07, 8);
        read_bits(32, w);
        spi_end();
        chk(w == 32'hA500_0007, "R10 fresh decode after abort", w, 32'hA500_0007);
        chk(spi_miso_oe == 1'b0, "R10 output released", 32'(spi_miso_oe), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule